// File: doc/BRIEF.md
# Image Sensor Pixel Window Capture

This block pulls one window of pixel samples out of a CMOS image sensor's video stream and writes it into a capture RAM of 1024 words by 8 bits. It runs entirely on the pixel clock that the sensor drives, so sensor data, frame and line qualifiers are sampled without any clock-domain crossing. The only asynchronous input is the host's capture request, which passes through a two-stage flip-flop synchronizer before the control logic sees it.

Once a capture is requested, the block first discards a programmable number of valid pixels and then writes a programmable number of valid pixels to consecutive RAM addresses starting at zero. A pixel is valid on a clock where the frame and line qualifiers are both high. One counter, wider than the RAM address, serves both phases, and its low bits address the RAM. When the window is complete the block raises a done flag and holds it until the host withdraws its request. The RAM itself sits outside this block and is driven through the write port outputs.

Top module: `pixcap_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle: after that edge `ram_we` and `cap_done` are 0 and the counter is cleared.
- R2: `cap_en_async` acts only after a two-flip-flop synchronizer: a change on it is first seen by the control logic at the second rising edge after it changes, so the earliest resulting action shows on the outputs after the third edge.
- R3: A pixel counts (in either phase) only on a clock where both `frame_ok` and `line_ok` are 1; a pixel with either qualifier low is neither counted nor written.
- R4: In the skip phase valid pixels advance the counter and are never written; when the counter equals `skip_num` the counter is cleared and the capture phase begins on the next clock. The single clock spent on this exit neither counts nor writes its pixel.
- R5: In the capture phase each valid pixel gives exactly one `ram_we` pulse, one clock after the edge that sampled it, with `ram_wdata` equal to that pixel and `ram_addr` equal to the capture count before that pixel (0 for the first); successive writes step the address by one.
- R6: A capture writes exactly `take_num` pixels; on the clock where the counter equals `take_num` the block moves to the done state and writes nothing further.
- R7: `cap_done` is 1 exactly while the block is in the done state; it stays 1 while the synchronized request stays high, and the block returns to idle (`cap_done` 0) once the synchronized request is low.
- R8: If the synchronized request goes low during skip or capture, the block returns to idle and issues no write on the following clock or after.
- R9: With `skip_num` equal to 0, the block goes from idle directly to the capture phase and writes the first valid pixel it sees there.
- R10: The counter has `CNT_W` bits (default 12), wider than the 10-bit RAM address; `ram_addr` is the counter's low 10 bits, so a window longer than 1024 pixels wraps the address to 0 after 1023.
- R11: With `take_num` equal to 0, the block enters the done state without any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pix | input | 1 | Pixel clock from the sensor; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en_async | input | 1 | Capture request from the host, asynchronous to `clk_pix` |
| frame_ok | input | 1 | Frame qualifier from the sensor |
| line_ok | input | 1 | Line qualifier from the sensor |
| pix_in | input | PIX_W (8) | Pixel sample from the sensor |
| skip_num | input | CNT_W (12) | Number of valid pixels to discard before capture |
| take_num | input | CNT_W (12) | Number of valid pixels to write |
| ram_we | output | 1 | Capture RAM write enable, one clock per written pixel |
| ram_addr | output | ADDR_W (10) | Capture RAM write address |
| ram_wdata | output | PIX_W (8) | Capture RAM write data |
| cap_done | output | 1 | High while the window is complete and the request stays high |

## Verification
The capture path is driven with an unbroken stream of valid pixels, with lines separated by blanking gaps, and with frame and line qualifiers toggling independently, which separates correct qualification from counting on either qualifier alone and exposes the pixel lost on the skip-to-capture transition. Zero skip and zero capture lengths check that the compares act from idle, a request dropped mid-capture checks the abort path, and a window longer than the RAM checks that the address wraps while the counter does not. Every clock the outputs are compared with a behavioural model fed from the same stimulus, and at the end of each window the number of writes is checked against the requested length.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

    localparam int unsigned PIX_W_DEF      = 8;
    localparam int unsigned RAM_WORDS_DEF  = 1024;
    localparam int unsigned CNT_W_DEF      = 12;
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    // Phase of the capture sequence.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SKIP = 2'd1,
        PH_TAKE = 2'd2,
        PH_DONE = 2'd3
    } cap_phase_e;

    // Per-clock commands from the sequencer to the datapath.
    typedef struct packed {
        logic clr;   // clear the shared counter
        logic inc;   // advance the shared counter
        logic wr;    // write the current pixel
    } cap_ctl_t;

    function automatic int unsigned addr_bits(input int unsigned words);
        return (words < 2) ? 1 : $clog2(words);
    endfunction

endpackage

// File: rtl/pixcap_sync.sv
module pixcap_sync #(
    parameter int unsigned STAGES = pixcap_pkg::SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= (chain << 1) | STAGES'(d_async);
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pixcap_count.sv
module pixcap_count #(
    parameter int unsigned CNT_W = pixcap_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pixcap_seq.sv
module pixcap_seq
    import pixcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,        // synchronized capture request
    input  logic       pix_ok,     // both qualifiers high
    input  logic       skip_hit,   // counter equals skip length
    input  logic       take_hit,   // counter equals capture length
    output cap_phase_e phase,
    output cap_ctl_t   ctl
);
    cap_phase_e phase_nxt;

    always_comb begin
        phase_nxt = phase;
        ctl       = '0;
        case (phase)
            PH_IDLE: begin
                ctl.clr = 1'b1;
                if (req) begin
                    phase_nxt = skip_hit ? PH_TAKE : PH_SKIP;
                end
            end
            PH_SKIP: begin
                if (!req) begin
                    phase_nxt = PH_IDLE;
                end else if (skip_hit) begin
                    phase_nxt = PH_TAKE;
                    ctl.clr   = 1'b1;
                end else begin
                    ctl.inc = pix_ok;
                end
            end
            PH_TAKE: begin
                if (!req) begin
                    phase_nxt = PH_IDLE;
                end else if (take_hit) begin
                    phase_nxt = PH_DONE;
                end else begin
                    ctl.inc = pix_ok;
                    ctl.wr  = pix_ok;
                end
            end
            PH_DONE: begin
                if (!req) begin
                    phase_nxt = PH_IDLE;
                end
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end
endmodule

// File: rtl/pixcap_ctrl.sv
module pixcap_ctrl
    import pixcap_pkg::*;
#(
    parameter int unsigned PIX_W      = PIX_W_DEF,
    parameter int unsigned RAM_WORDS  = RAM_WORDS_DEF,
    parameter int unsigned CNT_W      = CNT_W_DEF,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
    parameter int unsigned ADDR_W     = addr_bits(RAM_WORDS)
) (
    input  logic              clk_pix,
    input  logic              rst_n,
    input  logic              cap_en_async,
    input  logic              frame_ok,
    input  logic              line_ok,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic [CNT_W-1:0]  skip_num,
    input  logic [CNT_W-1:0]  take_num,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [PIX_W-1:0]  ram_wdata,
    output logic              cap_done
);
    logic             en_sync;
    logic             pix_ok;
    logic             skip_hit;
    logic             take_hit;
    logic [CNT_W-1:0] count;
    cap_phase_e       phase;
    cap_ctl_t         ctl;

    pixcap_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk_pix),
        .rst_n   (rst_n),
        .d_async (cap_en_async),
        .q_sync  (en_sync)
    );

    assign pix_ok   = frame_ok & line_ok;
    assign skip_hit = (count == skip_num);
    assign take_hit = (count == take_num);

    pixcap_seq u_seq (
        .clk      (clk_pix),
        .rst_n    (rst_n),
        .req      (en_sync),
        .pix_ok   (pix_ok),
        .skip_hit (skip_hit),
        .take_hit (take_hit),
        .phase    (phase),
        .ctl      (ctl)
    );

    pixcap_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk_pix),
        .rst_n (rst_n),
        .clr   (ctl.clr),
        .inc   (ctl.inc),
        .cnt   (count)
    );

    // Registered write port toward the capture RAM.
    always_ff @(posedge clk_pix) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= ctl.wr;
            if (ctl.wr) begin
                ram_addr  <= count[ADDR_W-1:0];
                ram_wdata <= pix_in;
            end
        end
    end

    assign cap_done = (phase == PH_DONE);
endmodule

// File: rtl/pixcap_ctrl_chk.sv
module pixcap_ctrl_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_s,
    input logic              frame_ok,
    input logic              line_ok,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              cap_done
);
    assert_qualified_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(frame_ok && line_ok));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

    assert_done_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |-> !ram_we);

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && en_s) |=> cap_done);

    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> !ram_we);
endmodule

bind pixcap_ctrl pixcap_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk_pix),
    .rst_n    (rst_n),
    .en_s     (en_sync),
    .frame_ok (frame_ok),
    .line_ok  (line_ok),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .cap_done (cap_done)
);

// File: tb/pixcap_ctrl_tb_top.sv
module pixcap_ctrl_tb_top;
    localparam int PW    = 8;
    localparam int WORDS = 1024;
    localparam int CW    = 12;
    localparam int AW    = 10;

    logic          clk = 1'b0;
    logic          b_rst_n = 1'b0;
    logic          b_en = 1'b0;
    logic          b_fv = 1'b0;
    logic          b_lv = 1'b0;
    logic [PW-1:0] b_d = '0;
    logic [CW-1:0] b_skip = '0;
    logic [CW-1:0] b_take = '0;

    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [PW-1:0] ram_wdata;
    logic          cap_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int gc = 0;
    int wcount = 0;

    // Behavioural reference state.
    int m_s1 = 0, m_s2 = 0, m_ph = 0, m_n = 0;
    int m_we = 0, m_addr = 0, m_data = 0;

    always #5 clk = ~clk;

    pixcap_ctrl #(.PIX_W(PW), .RAM_WORDS(WORDS), .CNT_W(CW)) dut_i (
        .clk_pix      (clk),
        .rst_n        (b_rst_n),
        .cap_en_async (b_en),
        .frame_ok     (b_fv),
        .line_ok      (b_lv),
        .pix_in       (b_d),
        .skip_num     (b_skip),
        .take_num     (b_take),
        .ram_we       (ram_we),
        .ram_addr     (ram_addr),
        .ram_wdata    (ram_wdata),
        .cap_done     (cap_done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Advance the reference by one clock using the inputs the design sampled.
    task automatic model_step();
        int en_now;
        int valid;
        en_now = m_s2;
        valid  = (b_fv && b_lv) ? 1 : 0;
        m_we   = 0;
        if (!b_rst_n) begin
            m_s1 = 0; m_s2 = 0; m_ph = 0; m_n = 0; m_addr = 0; m_data = 0;
            return;
        end
        case (m_ph)
            0: begin
                m_n = 0;
                if (en_now != 0) m_ph = (b_skip == 0) ? 2 : 1;
            end
            1: begin
                if (en_now == 0) m_ph = 0;
                else if (m_n == int'(b_skip)) begin m_ph = 2; m_n = 0; end
                else m_n += valid;
            end
            2: begin
                if (en_now == 0) m_ph = 0;
                else if (m_n == int'(b_take)) m_ph = 3;
                else if (valid != 0) begin
                    m_we = 1; m_addr = m_n % WORDS; m_data = int'(b_d); m_n++;
                end
            end
            default: if (en_now == 0) m_ph = 0;
        endcase
        m_s2 = m_s1;
        m_s1 = b_en ? 1 : 0;
    endtask

    // One clock with a given qualifier pattern; compare on the falling edge.
    task automatic tick(input string tag, input int mode);
        case (mode)
            0: begin b_fv = 1'b1; b_lv = 1'b1; end
            1: begin b_fv = 1'b1; b_lv = ((gc % 11) < 8); end
            2: begin b_fv = ((gc % 17) < 12); b_lv = ((gc % 5) < 3); end
            default: begin b_fv = 1'b0; b_lv = 1'b0; end
        endcase
        b_d = PW'(gc * 37 + 11);
        gc++;
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (ram_we) wcount++;
        chk(tag, "ram_we", int'(ram_we), m_we);
        chk(tag, "cap_done", int'(cap_done), (m_ph == 3) ? 1 : 0);
        if (m_we != 0) begin
            chk(tag, "ram_addr", int'(ram_addr), m_addr);
            chk(tag, "ram_wdata", int'(ram_wdata), m_data);
        end
    endtask

    task automatic run(input string tag, input int n, input int mode);
        for (int i = 0; i < n; i++) tick(tag, mode);
    endtask

    task automatic release_req(input string tag);
        b_en = 1'b0;
        run(tag, 4, 3);
        chk(tag, "cap_done after release", int'(cap_done), 0);
    endtask

    initial begin
        // R1: reset state
        b_rst_n = 1'b0;
        run("R1", 3, 0);
        chk("R1", "ram_we in reset", int'(ram_we), 0);
        chk("R1", "cap_done in reset", int'(cap_done), 0);
        b_rst_n = 1'b1;

        // R4 / R5: skip then capture over gapped lines
        wcount = 0; b_skip = 12'd5; b_take = 12'd20; b_en = 1'b1;
        run("R5", 60, 1);
        chk("R6", "writes in window", wcount, 20);
        chk("R4", "done after window", int'(cap_done), 1);
        // R7: done held while request stays high
        run("R7", 10, 0);
        chk("R7", "done held", int'(cap_done), 1);
        chk("R7", "no extra writes", wcount, 20);
        release_req("R7");

        // R9 / R2: no skip, continuous stream, synchronizer latency
        wcount = 0; b_skip = 12'd0; b_take = 12'd10; b_en = 1'b1;
        run("R2", 3, 0);
        chk("R2", "no write before sync", wcount, 0);
        run("R9", 17, 0);
        chk("R9", "writes with zero skip", wcount, 10);
        release_req("R9");

        // R3: independent frame and line gating
        wcount = 0; b_skip = 12'd3; b_take = 12'd15; b_en = 1'b1;
        run("R3", 90, 2);
        chk("R3", "writes with gated qualifiers", wcount, 15);
        release_req("R3");

        // R8: request dropped mid-capture
        wcount = 0; b_skip = 12'd4; b_take = 12'd50; b_en = 1'b1;
        run("R8", 20, 0);
        b_en = 1'b0;
        run("R8", 3, 0);
        wcount = 0;
        run("R8", 10, 0);
        chk("R8", "writes after abort", wcount, 0);
        chk("R8", "done after abort", int'(cap_done), 0);

        // R11: zero-length capture
        wcount = 0; b_skip = 12'd2; b_take = 12'd0; b_en = 1'b1;
        run("R11", 15, 0);
        chk("R11", "writes with zero length", wcount, 0);
        chk("R11", "done with zero length", int'(cap_done), 1);
        release_req("R11");

        // R10: window longer than the RAM wraps the address
        wcount = 0; b_skip = 12'd2; b_take = 12'd1030; b_en = 1'b1;
        run("R10", 1045, 0);
        chk("R10", "writes in long window", wcount, 1030);
        chk("R10", "last address wrapped", int'(ram_addr), 1029 % WORDS);
        release_req("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule